// File: doc/BRIEF.md
# Two-Level Masked Priority Interrupt Controller

This block sits between a bank of peripheral interrupt sources and a small CPU core. Each source has a request flag, an enable bit and a one-bit priority level. The controller also takes the CPU's global mask bit, a non-maskable interrupt pin and an address-break request. From these it picks at most one winner and presents it to the core as a request line plus a binary vector number.

The core takes the pending request only at an instruction boundary, which it marks by pulsing an input. On that acceptance the controller clears its request and, one cycle later, pulses an output that the core uses to set its mask bit. Arbitration is registered. Once a winner is on the outputs it stays there until the core takes it, so a request that arrives later cannot change the vector that is being acknowledged. A configurable subgroup of sources ignores the level bits and is gated only by the mask bit.

Top module: `pic2_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `irq_req`, `set_mask` and `irq_vec` are all 0.
- R2: A peripheral source whose enable bit is 0 is never presented, even when its flag is 1.
- R3: While `cpu_mask` is 1, no peripheral source is presented. The non-maskable and address-break requests are still presented.
- R4: While `cpu_mask` is 0, a source outside the subgroup whose level bit is 0 is held pending as long as any enabled, flagged source outside the subgroup has its level bit at 1.
- R5: Subgroup sources (those with a 1 bit in `GRP_MASK`, default bits 5 to 7) ignore their level bit. They are eligible whenever `cpu_mask` is 0, and their level bits never block a level-0 source.
- R6: Among eligible requests the fixed order is: non-maskable first, address break second, then peripheral sources by ascending index, with index 0 highest.
- R7: `irq_vec` carries the source index for a peripheral, `NSRC` for the non-maskable request and `NSRC+1` for address break. With the defaults these are 0 to 7, 8 and 9.
- R8: A winner chosen from the inputs sampled at a clock edge appears on `irq_req`/`irq_vec` right after that edge. `irq_vec` then holds steady until acceptance.
- R9: Acceptance happens only on a cycle where both `irq_req` and `insn_end` are 1. `insn_end` without a request has no effect.
- R10: After acceptance `irq_req` is 0 and `set_mask` is 1 for exactly one cycle. No new request is presented during that cycle.
- R11: The non-maskable pin is detected on its rising edge and latched. A pin held high does not retrigger, and the latch clears when its vector is accepted.
- R12: A higher-priority request that arrives while a winner is being presented does not replace the presented vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | NSRC | Level-sensitive peripheral request flags |
| src_en | input | NSRC | Per-source enable bits |
| src_level | input | NSRC | Per-source priority level (1 = preferred) |
| cpu_mask | input | 1 | Global interrupt mask bit from the core |
| nmi_pin | input | 1 | Non-maskable interrupt, edge detected |
| brk_req | input | 1 | Address-break request, level |
| insn_end | input | 1 | Instruction-boundary acknowledge strobe |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector number of the presented request |
| set_mask | output | 1 | One-cycle pulse that sets the core's mask bit |

## Verification
A request, including one caused by a fresh edge on the non-maskable pin, is due on the outputs after the first clock edge that samples it. `set_mask` rises, and `irq_req` falls, after the edge at which `insn_end` meets a presented request. The earliest next winner comes one edge after that. The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares all three outputs on every falling edge, half a period after the registers change, so each result is checked in the cycle it is due. Its model of the core also raises `cpu_mask` on the cycle after it sees `set_mask`, so the masking window follows the real handshake.

// File: rtl/pic2_pkg.sv
package pic2_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_NMI  = 2'd1,
        SEL_BRK  = 2'd2,
        SEL_SRC  = 2'd3
    } sel_kind_e;
endpackage

// File: rtl/pic2_qualify.sv
module pic2_qualify #(
    parameter int              NSRC     = 8,
    parameter logic [NSRC-1:0] GRP_MASK = 8'hE0
) (
    input  logic [NSRC-1:0] src_flag,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_level,
    input  logic            cpu_mask,
    output logic [NSRC-1:0] elig
);
    logic [NSRC-1:0] active;
    logic            hi_any;

    assign active = src_flag & src_en;
    // only sources outside the subgroup take part in the level split
    assign hi_any = |(active & src_level & ~GRP_MASK);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (GRP_MASK[i]) begin : g_grp
            assign elig[i] = active[i] & ~cpu_mask;
        end else begin : g_lvl
            assign elig[i] = active[i] & ~cpu_mask & (src_level[i] | ~hi_any);
        end
    end
endmodule

// File: rtl/pic2_prienc.sv
module pic2_prienc
    import pic2_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  elig,
    input  logic             nmi_hit,
    input  logic             brk_hit,
    output sel_kind_e        kind,
    output logic [IDX_W-1:0] idx
);
    logic [NSRC:0]   seen;
    logic [NSRC-1:0] grant;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign grant[i]  = elig[i] & ~seen[i];
        assign seen[i+1] = seen[i] | elig[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

    always_comb begin
        if (nmi_hit)           kind = SEL_NMI;
        else if (brk_hit)      kind = SEL_BRK;
        else if (seen[NSRC])   kind = SEL_SRC;
        else                   kind = SEL_NONE;
    end
endmodule

// File: rtl/pic2_top.sv
module pic2_top
    import pic2_pkg::*;
#(
    parameter int              NSRC     = 8,
    parameter logic [NSRC-1:0] GRP_MASK = 8'hE0,
    parameter int              VEC_W    = $clog2(NSRC + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_flag,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_level,
    input  logic             cpu_mask,
    input  logic             nmi_pin,
    input  logic             brk_req,
    input  logic             insn_end,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             set_mask
);
    localparam int               IDX_W    = $clog2(NSRC);
    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NSRC);
    localparam logic [VEC_W-1:0] BRK_CODE = VEC_W'(NSRC + 1);

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        logic             setm;
        logic             nmi_prev;
        logic             nmi_pend;
    } state_t;

    state_t          st_d, st_q;
    logic [NSRC-1:0] elig;
    logic            nmi_rise;
    logic            nmi_now;
    sel_kind_e       kind;
    logic [IDX_W-1:0] idx;

    assign nmi_rise = nmi_pin & ~st_q.nmi_prev;
    assign nmi_now  = st_q.nmi_pend | nmi_rise;

    pic2_qualify #(.NSRC(NSRC), .GRP_MASK(GRP_MASK)) qual_i (
        .src_flag (src_flag),
        .src_en   (src_en),
        .src_level(src_level),
        .cpu_mask (cpu_mask),
        .elig     (elig)
    );

    pic2_prienc #(.NSRC(NSRC), .IDX_W(IDX_W)) enc_i (
        .elig   (elig),
        .nmi_hit(nmi_now),
        .brk_hit(brk_req),
        .kind   (kind),
        .idx    (idx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.setm     = 1'b0;
        st_d.nmi_prev = nmi_pin;
        st_d.nmi_pend = nmi_now;
        if (st_q.req && insn_end) begin
            // accepted at an instruction boundary
            st_d.req  = 1'b0;
            st_d.setm = 1'b1;
            if (st_q.vec == NMI_CODE) st_d.nmi_pend = nmi_rise;
        end else if (!st_q.req && !st_q.setm) begin
            // free to arbitrate; the pulse cycle gives the core time to mask
            unique case (kind)
                SEL_NMI: begin st_d.req = 1'b1; st_d.vec = NMI_CODE;       end
                SEL_BRK: begin st_d.req = 1'b1; st_d.vec = BRK_CODE;       end
                SEL_SRC: begin st_d.req = 1'b1; st_d.vec = VEC_W'(idx);    end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req  = st_q.req;
    assign irq_vec  = st_q.vec;
    assign set_mask = st_q.setm;
endmodule

// File: rtl/pic2_chk.sv
module pic2_chk #(
    parameter int NSRC  = 8,
    parameter int VEC_W = $clog2(NSRC + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_flag,
    input logic [NSRC-1:0]  src_en,
    input logic             cpu_mask,
    input logic             insn_end,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             set_mask
);
    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NSRC);

    AST_ACK_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && insn_end |=> set_mask && !irq_req); // R10
    AST_MASK_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask |=> !set_mask && !irq_req); // R10
    AST_MASK_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(set_mask) |-> $past(irq_req && insn_end)); // R9
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !insn_end |=> irq_req && $stable(irq_vec)); // R12
    AST_MASKED_NO_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) && $past(cpu_mask) |-> irq_vec >= NMI_CODE); // R3
    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) && irq_vec < NMI_CODE
            |-> (($past(src_flag & src_en) >> irq_vec) & NSRC'(1)) != '0); // R2
endmodule

bind pic2_top pic2_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_flag(src_flag),
    .src_en  (src_en),
    .cpu_mask(cpu_mask),
    .insn_end(insn_end),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .set_mask(set_mask)
);

// File: tb/pic2_top_tb_top.sv
`timescale 1ns/1ps
module pic2_top_tb_top;
    localparam int         N   = 8;
    localparam logic [7:0] GRP = 8'hE0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_flag = '0, src_en = '0, src_level = '0;
    logic       cpu_mask = 1'b0, nmi_pin = 1'b0, brk_req = 1'b0, insn_end = 1'b0;
    logic       irq_req, set_mask;
    logic [3:0] irq_vec;

    int    checks = 0, errors = 0, cycles = 0;
    string tag = "R1";

    // behavioural reference
    bit m_req, m_setm, m_prev, m_pend;
    int m_vec;

    always #4 clk = ~clk;

    pic2_top #(.NSRC(N), .GRP_MASK(GRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .src_level(src_level), .cpu_mask(cpu_mask), .nmi_pin(nmi_pin),
        .brk_req(brk_req), .insn_end(insn_end), .irq_req(irq_req),
        .irq_vec(irq_vec), .set_mask(set_mask)
    );

    function automatic int pick(bit nmi_live);
        bit any_hi = 0;
        if (nmi_live) return N;
        if (brk_req) return N + 1;
        if (cpu_mask) return -1;
        for (int i = 0; i < N; i++)
            if (src_flag[i] && src_en[i] && src_level[i] && !GRP[i]) any_hi = 1;
        for (int i = 0; i < N; i++) begin
            if (!(src_flag[i] && src_en[i])) continue;
            if (GRP[i] || src_level[i] || !any_hi) return i;
        end
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req = 0; m_setm = 0; m_prev = 0; m_pend = 0; m_vec = 0;
        end else begin
            bit rise, live;
            int w;
            rise = nmi_pin && !m_prev;
            live = m_pend || rise;
            if (m_req && insn_end) begin
                m_req = 0; m_setm = 1;
                m_pend = (m_vec == N) ? rise : live;
            end else if (m_req || m_setm) begin
                m_setm = 0; m_pend = live;
            end else begin
                m_pend = live;
                w = pick(live);
                if (w >= 0) begin m_req = 1; m_vec = w; end
            end
            m_prev = nmi_pin;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // wait one cycle, compare at the falling edge, model the core's mask update
    task automatic cyc();
        @(negedge clk);
        checks++;
        if (irq_req !== m_req || set_mask !== m_setm || (m_req && irq_vec !== 4'(m_vec))
            || (!rst_n && irq_vec !== 4'd0)) begin
            errors++;
            $display("FAIL %s: actual req=%0b vec=%0d setm=%0b expected req=%0b vec=%0d setm=%0b",
                     tag, irq_req, irq_vec, set_mask, m_req, m_vec, m_setm);
        end
        insn_end = 1'b0;
        if (set_mask) cpu_mask = 1'b1;
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic ack();
        insn_end = 1'b1;
        cyc();
    endtask

    initial begin
        tag = "R1";
        run(3);
        rst_n = 1'b1;
        cyc();
        checks++;
        if (irq_req !== 1'b0 || set_mask !== 1'b0 || irq_vec !== 4'd0) begin
            errors++;
            $display("FAIL R1: actual req=%0b vec=%0d setm=%0b expected 0 0 0",
                     irq_req, irq_vec, set_mask);
        end

        tag = "R9"; insn_end = 1'b1; run(2);

        tag = "R2"; src_flag = 8'h04; src_en = 8'h00; run(4);
        src_en = 8'h04; run(3); ack(); run(3);          // R10 pulse, core masks

        tag = "R3"; src_flag = 8'hFF; src_en = 8'hFF; src_level = 8'h0F; run(4);
        brk_req = 1'b1; run(3); ack(); brk_req = 1'b0; run(2);
        nmi_pin = 1'b1; run(3); ack(); run(2);

        tag = "R11"; run(5); nmi_pin = 1'b0; run(1); nmi_pin = 1'b1; run(1);
        nmi_pin = 1'b0; run(3); ack(); run(3);

        tag = "R4"; src_flag = 8'h0F; src_en = 8'h0F; src_level = 8'h08; cpu_mask = 1'b0;
        run(2); ack(); run(2); cpu_mask = 1'b0; src_flag = 8'h07; run(2); ack(); run(2);

        tag = "R5"; cpu_mask = 1'b0; src_flag = 8'h21; src_en = 8'h21; src_level = 8'h20;
        run(2); ack(); run(2);
        cpu_mask = 1'b0; src_flag = 8'h62; src_level = 8'h00; src_en = 8'h60; run(2); ack(); run(2);
        tag = "R5"; src_flag = 8'hC0; src_en = 8'hC0; src_level = 8'h00; run(3);
        cpu_mask = 1'b0; run(2); ack(); run(2);

        tag = "R6"; cpu_mask = 1'b0; src_flag = 8'h1F; src_en = 8'hFF; src_level = 8'h10;
        brk_req = 1'b1; nmi_pin = 1'b0; run(1); nmi_pin = 1'b1;
        run(1); ack(); run(3); ack(); brk_req = 1'b0; run(2);
        cpu_mask = 1'b0; run(2); ack(); run(2);

        tag = "R7"; cpu_mask = 1'b0; nmi_pin = 1'b0; src_flag = 8'h80; src_en = 8'h80;
        src_level = 8'h00; run(2); ack(); run(2);

        tag = "R12"; cpu_mask = 1'b0; src_flag = 8'h08; src_en = 8'hFF; run(2);
        src_flag = 8'h09; src_level = 8'h01; nmi_pin = 1'b1; brk_req = 1'b1; run(4);
        tag = "R8"; ack(); run(2); ack(); run(2); brk_req = 1'b0; ack(); run(3);

        tag = "R10"; cpu_mask = 1'b0; src_flag = 8'h02; src_en = 8'h02; src_level = 8'h00;
        run(2); ack(); cpu_mask = 1'b0; run(1); cpu_mask = 1'b0; run(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule